// File: doc/BRIEF.md
# Cassette Tape Block Encoder

This block turns a block of bytes into the square-wave pulse train that is recorded on cassette tape. After a start strobe it sends a run of long leader pulses, then a short and a slightly longer sync pulse. It then sends the block's bytes: first a flag byte that marks the block as a header or a data block, then the payload, and finally a checksum byte that it computes itself. Every bit becomes two pulses of the same length, short for a zero and long for a one. Each pulse begins with a change of the output level. All durations are counted in cycles of the clock, which is meant to run at the recording machine's T-state rate.

Payload bytes arrive over a valid/ready handshake. A byte is taken only at the end of the previous byte's sixteenth pulse. If no byte is offered then, the output holds its level until one arrives. In header mode the payload length is fixed. In data mode the source marks the last byte. A done flag reports that the checksum byte has been sent.

Top module: `tape_block_encoder`

## Requirements
- R1: While reset is held and after it is released, `tape_o`, `done_o` and `in_ready_o` are all low.
- R2: A block begins on the rising edge where `start_i` is high and the encoder is idle or done. Every pulse begins with a toggle of `tape_o`, and the level is then held for the pulse's full duration in clock cycles.
- R3: The leader has `LEAD_HDR` pulses (default 8063) when `header_i` was high at start, and `LEAD_DAT` pulses (default 3223) otherwise. Each leader pulse lasts `LEAD_T` cycles (default 2168).
- R4: The leader is followed by one pulse of `SYNC1_T` cycles (default 667) and then one of `SYNC2_T` cycles (default 735).
- R5: Each byte is sent most significant bit first. A 0 bit is two pulses of `ZERO_T` cycles (default 855) and a 1 bit is two pulses of `ONE_T` cycles (default 1710).
- R6: The first byte after the sync pulses is a flag byte: 0x00 in header mode and 0xFF in data mode. It needs no handshake.
- R7: `in_ready_o` does not depend on `in_valid_i`. It is high only in the final cycle of a byte's sixteenth pulse when a payload byte is due, and while waiting for that byte. A byte moves on a rising edge where `in_valid_i` and `in_ready_o` are both high. Bytes are sent in the order they are received.
- R8: If no byte moves at the end of a byte, the output keeps its level (the last pulse is lengthened) until the transfer edge. The next pulse starts on that edge.
- R9: In header mode exactly `HDR_BYTES` payload bytes (default 17) are taken, and `in_last_i` is ignored. In data mode the payload ends with the byte whose `in_last_i` is high.
- R10: After the payload, a checksum byte is sent without a handshake. Its value is the XOR of the flag byte and all payload bytes, so the XOR of every byte on tape is 0x00.
- R11: `done_o` rises on the edge that ends the checksum's last pulse. From then on `tape_o` does not toggle, and `done_o` stays high until the next accepted start.
- R12: `start_i` is ignored while a block is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | T-state clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new block |
| header_i | input | 1 | 1 = header block, 0 = data block; sampled at start |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte offered |
| in_last_i | input | 1 | Marks the final payload byte of a data block |
| in_ready_o | output | 1 | Encoder takes a payload byte on this edge |
| tape_o | output | 1 | Tape output level |
| done_o | output | 1 | Block finished, held until next start |

## Verification
On every cycle, the assertions check that the output stays still while the encoder waits for a byte and after the block is done. They also check that ready only appears at a byte's final pulse, that the pulse timer is running in every active phase, that the header payload count stays in bounds, and that done follows the checksum byte. Only the bench's scenarios can show that the whole pulse train is right: leader counts for both modes, sync lengths, bit order, flag and checksum values, lengthened pulses under stalls, and immunity to a start strobe in mid-block. The bench compares every measured pulse length against a list it builds from the requirements.

// File: rtl/tape_enc_pkg.sv
package tape_enc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_SYNC1 = 3'd2,
    PH_SYNC2 = 3'd3,
    PH_DATA  = 3'd4,
    PH_WAIT  = 3'd5,
    PH_DONE  = 3'd6
  } phase_t;

  typedef enum logic [1:0] {
    BK_FLAG = 2'd0,
    BK_PAY  = 2'd1,
    BK_SUM  = 2'd2
  } bkind_t;
endpackage

// File: rtl/tape_rst_sync.sv
module tape_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tape_pulse_timer.sv
module tape_pulse_timer #(
  parameter int DUR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             end_o,
  output logic             busy_o
);
  logic [DUR_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = load_i || (rem_q != '0);
    rem_d  = load_i ? dur_i : (rem_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign end_o  = (rem_q == {{(DUR_W-1){1'b0}}, 1'b1});
  assign busy_o = (rem_q != '0);

  // R2: every pulse started has a non-zero length
  assert_nonzero_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (dur_i != '0));
endmodule

// File: rtl/tape_byte_ser.sv
module tape_byte_ser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_flag_i,
  input  logic [7:0] flag_i,
  input  logic       ld_pay_i,
  input  logic [7:0] pay_i,
  input  logic       ld_sum_i,
  input  logic       adv_i,
  output logic       next_bit_o,
  output logic       sum_msb_o,
  output logic       last_pulse_o
);
  logic [7:0] shift_q, shift_d;
  logic [7:0] sum_q, sum_d;
  logic [3:0] pidx_q, pidx_d;
  logic       reg_en;

  always_comb begin
    shift_d = shift_q;
    sum_d   = sum_q;
    pidx_d  = pidx_q;
    reg_en  = ld_flag_i || ld_pay_i || ld_sum_i || adv_i;
    if (ld_flag_i) begin
      shift_d = flag_i;
      sum_d   = flag_i;
      pidx_d  = 4'd0;
    end else if (ld_pay_i) begin
      shift_d = pay_i;
      sum_d   = sum_q ^ pay_i;
      pidx_d  = 4'd0;
    end else if (ld_sum_i) begin
      shift_d = sum_q;
      pidx_d  = 4'd0;
    end else if (adv_i) begin
      pidx_d = pidx_q + 4'd1;
      if (pidx_q[0]) shift_d = {shift_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= 8'h00;
      sum_q   <= 8'h00;
      pidx_q  <= 4'd0;
    end else if (reg_en) begin
      shift_q <= shift_d;
      sum_q   <= sum_d;
      pidx_q  <= pidx_d;
    end
  end

  // second pulse of a bit repeats the bit; first pulse of the next bit reads the next one
  assign next_bit_o   = pidx_q[0] ? shift_q[6] : shift_q[7];
  assign sum_msb_o    = sum_q[7];
  assign last_pulse_o = &pidx_q;

  // R5: the sequencer never issues two serializer actions at once
  assert_one_action_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_flag_i, ld_pay_i, ld_sum_i, adv_i}));
  // R5: advancing past the sixteenth pulse never happens
  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !last_pulse_o);
endmodule

// File: rtl/tape_seq.sv
module tape_seq
  import tape_enc_pkg::*;
#(
  parameter int LEAD_T    = 2168,
  parameter int SYNC1_T   = 667,
  parameter int SYNC2_T   = 735,
  parameter int ZERO_T    = 855,
  parameter int ONE_T     = 1710,
  parameter int LEAD_HDR  = 8063,
  parameter int LEAD_DAT  = 3223,
  parameter int HDR_BYTES = 17,
  parameter int DUR_W     = 12,
  parameter int LCNT_W    = 13,
  parameter int PCNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             header_i,
  input  logic             in_valid_i,
  input  logic             in_msb_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic             tape_o,
  output logic             done_o,
  input  logic             tmr_end_i,
  input  logic             tmr_busy_i,
  output logic             tmr_load_o,
  output logic [DUR_W-1:0] tmr_dur_o,
  output logic             ld_flag_o,
  output logic [7:0]       flag_o,
  output logic             ld_pay_o,
  output logic             ld_sum_o,
  output logic             adv_o,
  input  logic             ser_next_bit_i,
  input  logic             ser_sum_msb_i,
  input  logic             ser_last_i
);
  phase_t              phase_q, phase_d;
  bkind_t              kind_q, kind_d;
  logic                hdr_q, hdr_d;
  logic                last_q, last_d;
  logic [LCNT_W-1:0]   lcnt_q, lcnt_d;
  logic [PCNT_W-1:0]   pcnt_q, pcnt_d;
  logic                tape_q;
  logic                pay_done;
  logic [LCNT_W-1:0]   lead_len;

  function automatic logic [DUR_W-1:0] bit_dur(input logic b);
    return b ? DUR_W'(ONE_T) : DUR_W'(ZERO_T);
  endfunction

  assign lead_len = hdr_q ? LCNT_W'(LEAD_HDR) : LCNT_W'(LEAD_DAT);
  assign pay_done = (kind_q == BK_PAY) &&
                    (hdr_q ? (pcnt_q == PCNT_W'(HDR_BYTES)) : last_q);
  assign flag_o   = hdr_q ? 8'h00 : 8'hFF;

  always_comb begin
    phase_d    = phase_q;
    kind_d     = kind_q;
    hdr_d      = hdr_q;
    last_d     = last_q;
    lcnt_d     = lcnt_q;
    pcnt_d     = pcnt_q;
    tmr_load_o = 1'b0;
    tmr_dur_o  = '0;
    ld_flag_o  = 1'b0;
    ld_pay_o   = 1'b0;
    ld_sum_o   = 1'b0;
    adv_o      = 1'b0;
    in_ready_o = 1'b0;
    unique case (phase_q)
      PH_IDLE, PH_DONE: begin
        if (start_i) begin
          phase_d    = PH_LEAD;
          hdr_d      = header_i;
          lcnt_d     = LCNT_W'(1);
          pcnt_d     = '0;
          last_d     = 1'b0;
          tmr_load_o = 1'b1;
          tmr_dur_o  = DUR_W'(LEAD_T);
        end
      end
      PH_LEAD: begin
        if (tmr_end_i) begin
          tmr_load_o = 1'b1;
          if (lcnt_q == lead_len) begin
            phase_d   = PH_SYNC1;
            tmr_dur_o = DUR_W'(SYNC1_T);
          end else begin
            lcnt_d    = lcnt_q + 1'b1;
            tmr_dur_o = DUR_W'(LEAD_T);
          end
        end
      end
      PH_SYNC1: begin
        if (tmr_end_i) begin
          phase_d    = PH_SYNC2;
          tmr_load_o = 1'b1;
          tmr_dur_o  = DUR_W'(SYNC2_T);
        end
      end
      PH_SYNC2: begin
        if (tmr_end_i) begin
          phase_d    = PH_DATA;
          kind_d     = BK_FLAG;
          ld_flag_o  = 1'b1;
          tmr_load_o = 1'b1;
          tmr_dur_o  = bit_dur(!hdr_q);
        end
      end
      PH_DATA: begin
        if (tmr_end_i) begin
          if (!ser_last_i) begin
            adv_o      = 1'b1;
            tmr_load_o = 1'b1;
            tmr_dur_o  = bit_dur(ser_next_bit_i);
          end else if (kind_q == BK_SUM) begin
            phase_d = PH_DONE;
          end else if (pay_done) begin
            kind_d     = BK_SUM;
            ld_sum_o   = 1'b1;
            tmr_load_o = 1'b1;
            tmr_dur_o  = bit_dur(ser_sum_msb_i);
          end else begin
            in_ready_o = 1'b1;
            if (in_valid_i) begin
              kind_d     = BK_PAY;
              ld_pay_o   = 1'b1;
              last_d     = in_last_i;
              if (hdr_q) pcnt_d = pcnt_q + 1'b1;
              tmr_load_o = 1'b1;
              tmr_dur_o  = bit_dur(in_msb_i);
            end else begin
              phase_d = PH_WAIT;
            end
          end
        end
      end
      PH_WAIT: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          phase_d    = PH_DATA;
          kind_d     = BK_PAY;
          ld_pay_o   = 1'b1;
          last_d     = in_last_i;
          if (hdr_q) pcnt_d = pcnt_q + 1'b1;
          tmr_load_o = 1'b1;
          tmr_dur_o  = bit_dur(in_msb_i);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      kind_q  <= BK_FLAG;
      hdr_q   <= 1'b0;
      last_q  <= 1'b0;
      lcnt_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      hdr_q   <= hdr_d;
      last_q  <= last_d;
      lcnt_q  <= lcnt_d;
      pcnt_q  <= pcnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tape_q <= 1'b0;
    else if (tmr_load_o) tape_q <= ~tape_q;
  end

  assign tape_o = tape_q;
  assign done_o = (phase_q == PH_DONE);

  // R7: ready is only offered while the serializer sits on a byte's last pulse
  assert_ready_at_byte_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> ser_last_i);
  // R8: a stall keeps the tape level frozen
  assert_wait_holds_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && $past(phase_q) == PH_WAIT) |-> $stable(tape_q));
  // R11: nothing toggles once the block is done
  assert_done_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(tape_q));
  // R2: the pulse timer is running in every pulse-emitting phase
  assert_timer_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LEAD || phase_q == PH_SYNC1 || phase_q == PH_SYNC2 || phase_q == PH_DATA)
      |-> tmr_busy_i);
  // R9: header payload count never passes its fixed length
  assert_hdr_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_q |-> (pcnt_q <= PCNT_W'(HDR_BYTES)));
  // R10: done only follows the checksum byte
  assert_done_after_sum_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(kind_q == BK_SUM));
endmodule

// File: rtl/tape_block_encoder.sv
module tape_block_encoder #(
  parameter int LEAD_T    = 2168,
  parameter int SYNC1_T   = 667,
  parameter int SYNC2_T   = 735,
  parameter int ZERO_T    = 855,
  parameter int ONE_T     = 1710,
  parameter int LEAD_HDR  = 8063,
  parameter int LEAD_DAT  = 3223,
  parameter int HDR_BYTES = 17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       header_i,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic       tape_o,
  output logic       done_o
);
  localparam int DUR_M1   = (LEAD_T  > SYNC1_T) ? LEAD_T  : SYNC1_T;
  localparam int DUR_M2   = (SYNC2_T > ZERO_T)  ? SYNC2_T : ZERO_T;
  localparam int DUR_M3   = (DUR_M1  > DUR_M2)  ? DUR_M1  : DUR_M2;
  localparam int DUR_MAX  = (DUR_M3  > ONE_T)   ? DUR_M3  : ONE_T;
  localparam int DUR_W    = $clog2(DUR_MAX + 1);
  localparam int LEAD_MAX = (LEAD_HDR > LEAD_DAT) ? LEAD_HDR : LEAD_DAT;
  localparam int LCNT_W   = $clog2(LEAD_MAX + 1);
  localparam int PCNT_W   = $clog2(HDR_BYTES + 1);

  logic             rst_n;
  logic             tmr_load, tmr_end, tmr_busy;
  logic [DUR_W-1:0] tmr_dur;
  logic             ld_flag, ld_pay, ld_sum, adv;
  logic [7:0]       flag_val;
  logic             next_bit, sum_msb, last_pulse;

  tape_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  tape_pulse_timer #(.DUR_W(DUR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (tmr_load),
    .dur_i  (tmr_dur),
    .end_o  (tmr_end),
    .busy_o (tmr_busy)
  );

  tape_byte_ser u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .ld_flag_i    (ld_flag),
    .flag_i       (flag_val),
    .ld_pay_i     (ld_pay),
    .pay_i        (in_data_i),
    .ld_sum_i     (ld_sum),
    .adv_i        (adv),
    .next_bit_o   (next_bit),
    .sum_msb_o    (sum_msb),
    .last_pulse_o (last_pulse)
  );

  tape_seq #(
    .LEAD_T    (LEAD_T),
    .SYNC1_T   (SYNC1_T),
    .SYNC2_T   (SYNC2_T),
    .ZERO_T    (ZERO_T),
    .ONE_T     (ONE_T),
    .LEAD_HDR  (LEAD_HDR),
    .LEAD_DAT  (LEAD_DAT),
    .HDR_BYTES (HDR_BYTES),
    .DUR_W     (DUR_W),
    .LCNT_W    (LCNT_W),
    .PCNT_W    (PCNT_W)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_n),
    .start_i        (start_i),
    .header_i       (header_i),
    .in_valid_i     (in_valid_i),
    .in_msb_i       (in_data_i[7]),
    .in_last_i      (in_last_i),
    .in_ready_o     (in_ready_o),
    .tape_o         (tape_o),
    .done_o         (done_o),
    .tmr_end_i      (tmr_end),
    .tmr_busy_i     (tmr_busy),
    .tmr_load_o     (tmr_load),
    .tmr_dur_o      (tmr_dur),
    .ld_flag_o      (ld_flag),
    .flag_o         (flag_val),
    .ld_pay_o       (ld_pay),
    .ld_sum_o       (ld_sum),
    .adv_o          (adv),
    .ser_next_bit_i (next_bit),
    .ser_sum_msb_i  (sum_msb),
    .ser_last_i     (last_pulse)
  );
endmodule

// File: tb/tb_tape_block_encoder.sv
`timescale 1ns/1ps
module tb_tape_block_encoder;
  localparam int LEAD_T    = 7;
  localparam int SYNC1_T   = 3;
  localparam int SYNC2_T   = 4;
  localparam int ZERO_T    = 2;
  localparam int ONE_T     = 5;
  localparam int LEAD_HDR  = 9;
  localparam int LEAD_DAT  = 5;
  localparam int HDR_BYTES = 17;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, header, in_valid, in_last;
  logic [7:0] in_data;
  logic       in_ready, tape, done;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  int         exp_q[$];
  string      tag_q[$];
  logic [7:0] pay [32];
  int         st  [32];

  always #2 clk = ~clk;

  tape_block_encoder #(
    .LEAD_T(LEAD_T), .SYNC1_T(SYNC1_T), .SYNC2_T(SYNC2_T), .ZERO_T(ZERO_T),
    .ONE_T(ONE_T), .LEAD_HDR(LEAD_HDR), .LEAD_DAT(LEAD_DAT), .HDR_BYTES(HDR_BYTES)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .header_i(header),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last),
    .in_ready_o(in_ready), .tape_o(tape), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input string tg);
    for (int j = 7; j >= 0; j--) begin
      int d = b[j] ? ONE_T : ZERO_T;
      exp_q.push_back(d); tag_q.push_back(tg);
      exp_q.push_back(d); tag_q.push_back(tg);
    end
  endtask

  // Expected pulse list from R3..R10
  task automatic build_expected(input bit hdr, input int nb);
    logic [7:0] flag, sum;
    exp_q.delete(); tag_q.delete();
    for (int i = 0; i < (hdr ? LEAD_HDR : LEAD_DAT); i++) begin
      exp_q.push_back(LEAD_T); tag_q.push_back("R3");
    end
    exp_q.push_back(SYNC1_T); tag_q.push_back("R4");
    exp_q.push_back(SYNC2_T); tag_q.push_back("R4");
    flag = hdr ? 8'h00 : 8'hFF;
    sum  = flag;
    push_byte(flag, "R6");
    for (int i = 0; i < nb; i++) begin
      if (st[i] > 0) begin
        exp_q[exp_q.size()-1] = exp_q[exp_q.size()-1] + st[i];
        tag_q[tag_q.size()-1] = "R8";
      end
      push_byte(pay[i], "R5");
      sum = sum ^ pay[i];
    end
    push_byte(sum, "R10");
  endtask

  // pmode: 0 random, 1 all 0xFF, 2 all 0x00
  task automatic run_block(input bit hdr, input int nb_in, input int maxstall,
                           input int pmode, input bit mid);
    int  nb = hdr ? HDR_BYTES : nb_in;
    int  handshakes = 0;
    int  k = 0;
    logic lvl0;
    for (int i = 0; i < nb; i++) begin
      pay[i] = (pmode == 1) ? 8'hFF : (pmode == 2) ? 8'h00 : 8'($urandom);
      st[i]  = (maxstall > 0) ? int'($urandom % (maxstall + 1)) : 0;
    end
    build_expected(hdr, nb);
    @(negedge clk);
    lvl0   = tape;
    header = hdr;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    header = ~hdr;
    fork
      begin : drv
        for (int i = 0; i < nb; i++) begin
          int cnt = 0;
          bit got = 0;
          in_data  = pay[i];
          in_last  = hdr ? 1'($urandom % 2) : (i == nb - 1);
          in_valid = (st[i] == 0);
          while (!got) begin
            @(negedge clk);
            if (in_ready) begin
              if (in_valid) got = 1;
              else begin
                cnt++;
                if (cnt > st[i]) begin in_valid = 1'b1; got = 1; end
              end
            end
          end
          handshakes++;
          @(negedge clk);
          in_valid = 1'b0;
          in_last  = 1'b0;
        end
      end
      begin : mon
        logic cur = tape;
        int run = 1;
        check(tape != lvl0, "R2", "first pulse starts with a toggle", tape, !lvl0);
        while (1) begin
          @(negedge clk);
          if (done || tape != cur) begin
            if (k < exp_q.size())
              check(run == exp_q[k], tag_q[k], $sformatf("pulse %0d length", k), run, exp_q[k]);
            else
              check(0, "R11", "extra pulse", k, exp_q.size());
            k++;
            if (done) break;
            cur = tape;
            run = 1;
          end else begin
            run++;
          end
        end
      end
      begin : midstart
        if (mid) begin
          repeat (40) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    check(k == exp_q.size(), mid ? "R12" : "R11", "pulse count", k, exp_q.size());
    check(handshakes == nb, hdr ? "R9" : "R7", "payload bytes taken", handshakes, nb);
    begin
      logic lv = tape;
      repeat (6) @(negedge clk);
      check(done == 1'b1, "R11", "done held", done, 1);
      check(tape == lv, "R11", "no toggle after done", tape, lv);
      check(in_ready == 1'b0, "R7", "no ready when done", in_ready, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin : main
    void'($urandom(32'd90417));
    rst_n = 1'b0; start = 1'b0; header = 1'b0;
    in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    check(tape == 0, "R1", "tape in reset", tape, 0);
    check(done == 0, "R1", "done in reset", done, 0);
    check(in_ready == 0, "R1", "ready in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tape == 0, "R1", "tape after reset", tape, 0);
    check(done == 0, "R1", "done after reset", done, 0);
    check(in_ready == 0, "R1", "ready after reset", in_ready, 0);

    run_block(1'b1, 0, 0, 0, 1'b0);   // header, no stalls
    run_block(1'b0, 1, 0, 0, 1'b0);   // shortest data block
    run_block(1'b0, 5, 3, 1, 1'b0);   // all ones with stalls
    run_block(1'b1, 0, 2, 2, 1'b0);   // all zeros header with stalls
    run_block(1'b0, 8, 1, 0, 1'b1);   // start strobe in mid-block (R12)
    for (int b = 0; b < 5; b++) begin
      bit h = 1'($urandom % 2);
      run_block(h, 1 + int'($urandom % 12), int'($urandom % 4), 0, 1'b0);
    end
    report();
    $finish;
  end
endmodule